// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block performs 32-bit integer multiplication and division, in signed and unsigned forms, on a shared shift-and-add / shift-and-subtract datapath. It keeps its results in two private registers, HI and LO. A multiply fills HI and LO with the 64-bit product. A divide puts the quotient in LO and the remainder in HI. The results are not driven out directly. They are fetched one at a time through a read port, in the same way that separate move-from-HI and move-from-LO operations would fetch them.

A caller presents two operands and an operation code together with a one-cycle start strobe while the unit is idle. The unit raises `busy`, works on one bit per cycle, and updates HI and LO on the same clock edge on which `busy` drops. A caller can read the previous HI and LO at any time while the unit works. A start strobe that arrives during that time is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 multiplies the operands as two's-complement numbers; HI receives bits 63:32 and LO bits 31:0 of the signed 64-bit product.
- R2: Operation code 2'b01 multiplies the operands as unsigned numbers; HI receives bits 63:32 and LO bits 31:0 of the unsigned 64-bit product.
- R3: Operation code 2'b10 divides opA by opB as two's-complement numbers, rounding the quotient toward zero; LO receives the quotient and HI a remainder carrying the dividend's sign (the quotient of -2^31 by -1 wraps to 32'h80000000, the remainder is 0).
- R4: Operation code 2'b11 divides opA by opB as unsigned numbers; LO receives the quotient and HI the remainder.
- R5: A start strobe seen while `busy` is low is accepted; `busy` is high from the next cycle for exactly 33 cycles, and HI/LO take their new values on the edge where `busy` returns low.
- R6: A divide (either code) with opB equal to zero keeps the R5 timing but leaves HI and LO at their previous values.
- R7: While `busy` is high, reads return the HI and LO values held before the operation began.
- R8: A start strobe seen while `busy` is high has no effect: the running operation's timing and results are unchanged and no new operation follows it.
- R9: `readData` is HI when `readHi` is high, otherwise LO when `readLo` is high, otherwise zero; it follows the read inputs combinationally in the same cycle.
- R10: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start strobe for a new operation |
| opSel | input | 2 | Operation code: bit 1 selects divide, bit 0 selects unsigned |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| readHi | input | 1 | Request the HI register on readData |
| readLo | input | 1 | Request the LO register on readData |
| busy | output | 1 | Operation in progress |
| readData | output | 32 | Selected result register |

## Verification
The start strobe is taken on one edge. `busy` is due one edge later and stays high for 33 edges. HI and LO change only on the 34th edge counted from acceptance. The bench drives inputs on falling edges and samples `busy` just before that final edge and again just after it. It reads HI and LO only after `busy` has fallen, except where R7 requires reads during the run, because the read port is combinational and changes within the same half cycle. A checker counts the busy cycles so that the 33-cycle window does not depend on a long `$past` history.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdOp_e;

  typedef struct packed {
    logic load;    // capture operands and sign flags
    logic step;    // one iteration of shift-add or shift-subtract
    logic commit;  // write corrected results into HI/LO
  } mdStrobe_s;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startValid,
  output mdStrobe_s strobe,
  output logic      busy
);

  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_e;

  ctrlState_e state;
  logic [CW-1:0] stepCnt;
  logic accept;

  assign accept = startValid && (state == ST_IDLE);

  always_comb begin
    strobe.load   = accept;
    strobe.step   = (state == ST_RUN);
    strobe.commit = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) state <= ST_FIN;
          else                      stepCnt <= stepCnt + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mdStrobe_s        strobe,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readHi,
  input  logic             readLo,
  output logic [WIDTH-1:0] readData
);

  localparam int DW = 2 * WIDTH;

  // work register: upper half = partial product / remainder, lower = multiplier / quotient
  logic [DW-1:0]    workReg;
  logic [WIDTH-1:0] operandReg;
  logic             isDiv, negLow, negHigh, divZero;
  logic [WIDTH-1:0] hiReg, loReg;

  logic             opIsDiv, opIsSigned, aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;

  always_comb begin
    opIsDiv    = (opSel == OP_DIV_S) || (opSel == OP_DIV_U);
    opIsSigned = (opSel == OP_MUL_S) || (opSel == OP_DIV_S);
    aNeg       = opIsSigned && opA[WIDTH-1];
    bNeg       = opIsSigned && opB[WIDTH-1];
    aMag       = aNeg ? (~opA + 1'b1) : opA;
    bMag       = bNeg ? (~opB + 1'b1) : opB;
  end

  // one iteration of each algorithm
  logic [WIDTH:0]   addTerm, partialSum;
  logic [WIDTH:0]   shiftedRem;
  logic [WIDTH+1:0] trialDiff;
  logic [DW-1:0]    mulNext, divNext;

  always_comb begin
    addTerm    = workReg[0] ? {1'b0, operandReg} : '0;
    partialSum = {1'b0, workReg[DW-1:WIDTH]} + addTerm;
    mulNext    = {partialSum, workReg[WIDTH-1:1]};

    shiftedRem = {workReg[DW-1:WIDTH], workReg[WIDTH-1]};
    trialDiff  = {1'b0, shiftedRem} - {2'b00, operandReg};
    if (!trialDiff[WIDTH+1])
      divNext = {trialDiff[WIDTH-1:0], workReg[WIDTH-2:0], 1'b1};
    else
      divNext = {shiftedRem[WIDTH-1:0], workReg[WIDTH-2:0], 1'b0};
  end

  // sign correction of the finished magnitudes
  logic [DW-1:0]    prodFinal;
  logic [WIDTH-1:0] quotFinal, remFinal;

  always_comb begin
    prodFinal = negLow ? (~workReg + 1'b1) : workReg;
    quotFinal = negLow ? (~workReg[WIDTH-1:0] + 1'b1) : workReg[WIDTH-1:0];
    remFinal  = negHigh ? (~workReg[DW-1:WIDTH] + 1'b1) : workReg[DW-1:WIDTH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      workReg    <= '0;
      operandReg <= '0;
      isDiv      <= 1'b0;
      negLow     <= 1'b0;
      negHigh    <= 1'b0;
      divZero    <= 1'b0;
    end else if (strobe.load) begin
      isDiv   <= opIsDiv;
      negLow  <= aNeg ^ bNeg;
      negHigh <= aNeg;
      divZero <= (opB == '0);
      if (opIsDiv) begin
        workReg    <= {{WIDTH{1'b0}}, aMag};
        operandReg <= bMag;
      end else begin
        workReg    <= {{WIDTH{1'b0}}, bMag};
        operandReg <= aMag;
      end
    end else if (strobe.step) begin
      workReg <= isDiv ? divNext : mulNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobe.commit) begin
      if (!isDiv) begin
        hiReg <= prodFinal[DW-1:WIDTH];
        loReg <= prodFinal[WIDTH-1:0];
      end else if (!divZero) begin
        hiReg <= remFinal;
        loReg <= quotFinal;
      end
    end
  end

  always_comb begin
    if (readHi)      readData = hiReg;
    else if (readLo) readData = loReg;
    else             readData = '0;
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startValid,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readHi,
  input  logic             readLo,
  output logic             busy,
  output logic [WIDTH-1:0] readData
);

  mdStrobe_s strobe;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .strobe     (strobe),
    .busy       (busy)
  );

  muldiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .opSel    (opSel),
    .opA      (opA),
    .opB      (opB),
    .readHi   (readHi),
    .readLo   (readLo),
    .readData (readData)
  );

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startValid,
  input logic             readHi,
  input logic             readLo,
  input logic             busy,
  input logic [WIDTH-1:0] readData
);

  localparam int BUSY_LEN = WIDTH + 1;

  int unsigned busyCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= 0;
  end

  // R5: an idle start raises busy on the next cycle
  a_r5_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (startValid && !busy) |=> busy);

  // R5, R8: busy lasts exactly the fixed number of cycles even with extra starts
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyCnt == BUSY_LEN));

  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyCnt < BUSY_LEN));

  // R7: HI stays put while the unit works
  a_r7_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && readHi) |=> (!busy || !readHi || $stable(readData)));

  // R7: LO stays put while the unit works
  a_r7_lo_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && readLo && !readHi) |=> (!busy || readHi || !readLo || $stable(readData)));

  // R9: no read request gives zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!readHi && !readLo) |-> (readData == '0));

endmodule

bind muldiv_unit muldiv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startValid (startValid),
  .readHi     (readHi),
  .readLo     (readLo),
  .busy       (busy),
  .readData   (readData)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        readHi = 1'b0, readLo = 1'b0;
  logic        busy;
  logic [31:0] readData;

  int checks = 0;
  int failures = 0;
  logic [31:0] modelHi = '0, modelLo = '0;

  always #4 clk = ~clk;   // 125 MHz

  muldiv_unit dut (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .opSel(opSel),
    .opA(opA), .opB(opB), .readHi(readHi), .readLo(readLo),
    .busy(busy), .readData(readData)
  );

  // {opSel, opA, opB}
  localparam logic [65:0] VEC [12] = '{
    {2'd0, 32'hFFFFFFFD, 32'd7},
    {2'd0, 32'h80000000, 32'h80000000},
    {2'd0, 32'h7FFFFFFF, 32'hFFFFFFFF},
    {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'd1, 32'd12345,    32'd6789},
    {2'd2, 32'hFFFFFFF9, 32'd2},
    {2'd2, 32'd7,        32'hFFFFFFFE},
    {2'd2, 32'h80000000, 32'hFFFFFFFF},
    {2'd2, 32'hFFFFFFF9, 32'hFFFFFFFE},
    {2'd3, 32'hFFFFFFFF, 32'd10},
    {2'd3, 32'd5,        32'd9},
    {2'd3, 32'h80000000, 32'd1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // expected model, computed with wide native arithmetic
  task automatic modelOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sq, sr;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'd0: begin p = 64'(sa * sb); modelHi = p[63:32]; modelLo = p[31:0]; end
      2'd1: begin p = {32'd0, a} * {32'd0, b}; modelHi = p[63:32]; modelLo = p[31:0]; end
      2'd2: if (b != 0) begin
              sq = sa / sb; sr = sa % sb;
              modelLo = sq[31:0]; modelHi = sr[31:0];
            end
      default: if (b != 0) begin modelLo = a / b; modelHi = a % b; end
    endcase
  endtask

  task automatic readBoth(output logic [31:0] hi, output logic [31:0] lo);
    readHi = 1'b1; readLo = 1'b0; #1 hi = readData;
    readHi = 1'b0; readLo = 1'b1; #1 lo = readData;
    readLo = 1'b0; #1;
  endtask

  // drive a start at a falling edge; returns at the falling edge after acceptance
  task automatic startOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    opSel = op; opA = a; opB = b; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // waits the remaining cycles from a given count after acceptance, checking R5 timing
  task automatic finishOp(input int doneEdges, input string req);
    repeat (32 - doneEdges) @(negedge clk);
    check("R5", {req, " busy just before final edge"}, {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R5", {req, " busy after final edge"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic checkResults(input string req);
    logic [31:0] h, l;
    readBoth(h, l);
    check(req, "HI", h, modelHi);
    check(req, "LO", l, modelLo);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] h, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10", "busy after reset", {31'd0, busy}, 32'd0);
    readBoth(h, l);
    check("R10", "HI after reset", h, 32'd0);
    check("R10", "LO after reset", l, 32'd0);

    // vector table: R1..R4 with R5 timing
    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      op = VEC[i][65:64];
      startOp(op, VEC[i][63:32], VEC[i][31:0]);
      check("R5", "busy one cycle after start", {31'd0, busy}, 32'd1);
      modelOp(op, VEC[i][63:32], VEC[i][31:0]);
      finishOp(0, reqOf(op));
      checkResults(reqOf(op));
    end

    // R6: divide by zero, signed and unsigned, leaves HI/LO alone
    startOp(2'd2, 32'd100, 32'd0);
    finishOp(0, "R6");
    checkResults("R6");
    startOp(2'd3, 32'hDEADBEEF, 32'd0);
    finishOp(0, "R6");
    checkResults("R6");

    // R7 and R8: reads during busy, start while busy ignored
    begin
      logic [31:0] oldHi, oldLo;
      oldHi = modelHi; oldLo = modelLo;
      startOp(2'd1, 32'd1000, 32'd3000);
      repeat (10) @(negedge clk);
      readBoth(h, l);
      check("R7", "HI read while busy", h, oldHi);
      check("R7", "LO read while busy", l, oldLo);
      opSel = 2'd3; opA = 32'd77; opB = 32'd5; startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
      repeat (20) @(negedge clk);
      readBoth(h, l);
      check("R7", "HI read late in run", h, oldHi);
      check("R7", "LO read late in run", l, oldLo);
      modelOp(2'd1, 32'd1000, 32'd3000);
      finishOp(31, "R8");
      checkResults("R8");
      repeat (3) @(negedge clk);
      check("R8", "no follow-on operation", {31'd0, busy}, 32'd0);
      checkResults("R8");
    end

    // R9: read port priority and idle value
    readHi = 1'b1; readLo = 1'b1; #1;
    check("R9", "both requests give HI", readData, modelHi);
    readHi = 1'b0; readLo = 1'b0; #1;
    check("R9", "no request gives zero", readData, 32'd0);

    // R10: reset in mid-run clears everything
    startOp(2'd0, 32'd9, 32'd9);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "busy after mid-run reset", {31'd0, busy}, 32'd0);
    modelHi = '0; modelLo = '0;
    checkResults("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule